// File: doc/BRIEF.md
# Delay-Calibration Bring-Up Sequencer

This block orders the start-up of a set of I/O delay-calibration controllers that share one bank. It owns a single reset line that fans out to every controller, so all of them leave reset on the same clock edge; staggered release would break the daisy-chained readiness signals between neighbours and could leave one controller's delay-ready flag stuck low. After the reset hold, it waits for every controller to report that initial fixed-delay calibration is complete, and only then raises the voltage/temperature tracking enable. It keeps that enable high for as long as operation continues.

Both status lines per controller arrive with no relation to the local clock and pass through two flip-flops before any decision uses them. Each waiting phase is bounded by its own timeout. Once all tracking-ready flags are high the block reports completion. If any tracking-ready flag later drops, it reports loss of lock. From either error it stays parked, with the tracking enable low, until user logic requests a restart.

Top module: `dlycal_bringup`

## Requirements
- R1: While `sys_rst` is high, `ctrl_rst` is high, with no clock edge needed, and `en_track`, `bringup_done`, `err_timeout` and `err_lock` are low.
- R2: After `sys_rst` is released, and after each accepted restart, `ctrl_rst` stays high for exactly HOLD_CYCLES rising clock edges. It then falls on a single edge. One output bit drives every controller.
- R3: Each status input passes through a two-flop synchronizer. When the last `dly_rdy_in` bit rises between two clock edges, `en_track` goes high after the third rising edge that follows.
- R4: `en_track` stays low until all N_CTRL bits of `dly_rdy_in` have been seen high together. A subset of them being high is not enough.
- R5: Once raised, `en_track` stays high through the tracking wait and the completion state. It falls only when an error is flagged.
- R6: `bringup_done` goes high when all `vtc_rdy_in` bits are seen high while `en_track` is high.
- R7: If the delay-ready wait lasts DLY_TIMEOUT edges without all bits high, `err_timeout` is set and `en_track` stays low.
- R8: If the tracking-ready wait lasts VTC_TIMEOUT edges without all bits high, `err_timeout` is set and `en_track` falls.
- R9: While done, if any synchronized `vtc_rdy_in` bit is low, `err_lock` is set on the next edge, and `bringup_done` and `en_track` fall.
- R10: `restart` is obeyed only while an error flag is set. It then clears the flags and raises `ctrl_rst` on the next edge. In every other state it has no effect.
- R11: An error flag holds, with `ctrl_rst` low, until a restart. At most one of `bringup_done`, `err_timeout` and `err_lock` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| sys_rst | input | 1 | System reset, active high, asynchronous assert |
| restart | input | 1 | User request to rerun the sequence after an error |
| dly_rdy_in | input | N_CTRL | Per-controller delay-ready status, asynchronous |
| vtc_rdy_in | input | N_CTRL | Per-controller tracking-ready status, asynchronous |
| ctrl_rst | output | 1 | Shared reset to all controllers |
| en_track | output | 1 | Voltage/temperature tracking enable |
| bringup_done | output | 1 | Sequence complete and locked |
| err_timeout | output | 1 | A wait phase timed out |
| err_lock | output | 1 | Tracking-ready lost after completion |

## Verification
The bench builds the block with three controllers, a hold of 5 edges, and timeouts of 40 and 30 edges. These short windows let both timeout paths, the lock-loss path and several restarts fit into a few hundred cycles. With three controllers, a single controller that never becomes ready blocks the enable while the others are ready. Randomized ready latencies on each controller vary which bit arrives last, and so exercise the three-edge synchronizer delay from different positions.

// File: rtl/dlycal_bringup.sv
module dlycal_bringup #(
  parameter int N_CTRL      = 4,
  parameter int HOLD_CYCLES = 64,
  parameter int DLY_TIMEOUT = 4096,
  parameter int VTC_TIMEOUT = 65536
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              restart,
  input  logic [N_CTRL-1:0] dly_rdy_in,
  input  logic [N_CTRL-1:0] vtc_rdy_in,
  output logic              ctrl_rst,
  output logic              en_track,
  output logic              bringup_done,
  output logic              err_timeout,
  output logic              err_lock
);

  localparam int WMAX = (DLY_TIMEOUT > VTC_TIMEOUT) ? DLY_TIMEOUT : VTC_TIMEOUT;
  localparam int CMAX = (WMAX > HOLD_CYCLES) ? WMAX : HOLD_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_HOLD, S_WDLY, S_EN, S_WVTC, S_DONE, S_ERR} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [N_CTRL-1:0] dly_m, dly_s, vtc_m, vtc_s;
  logic all_dly, all_vtc;

  always_ff @(posedge clk or posedge sys_rst)
    if (sys_rst) begin
      dly_m <= '0; dly_s <= '0; vtc_m <= '0; vtc_s <= '0;
    end else begin
      dly_m <= dly_rdy_in; dly_s <= dly_m;
      vtc_m <= vtc_rdy_in; vtc_s <= vtc_m;
    end

  assign all_dly = &dly_s;
  assign all_vtc = &vtc_s;

  always_ff @(posedge clk or posedge sys_rst)
    if (sys_rst) begin
      st <= S_HOLD; cnt <= '0; ctrl_rst <= 1'b1;
      err_timeout <= 1'b0; err_lock <= 1'b0;
    end else begin
      case (st)
        S_HOLD:
          if (cnt == CW'(HOLD_CYCLES - 1)) begin
            st <= S_WDLY; cnt <= '0; ctrl_rst <= 1'b0;
          end else cnt <= cnt + 1'b1;
        S_WDLY:
          if (all_dly) begin
            st <= S_EN; cnt <= '0;
          end else if (cnt == CW'(DLY_TIMEOUT - 1)) begin
            st <= S_ERR; err_timeout <= 1'b1;
          end else cnt <= cnt + 1'b1;
        S_EN: begin
          st <= S_WVTC; cnt <= '0;
        end
        S_WVTC:
          if (all_vtc) st <= S_DONE;
          else if (cnt == CW'(VTC_TIMEOUT - 1)) begin
            st <= S_ERR; err_timeout <= 1'b1;
          end else cnt <= cnt + 1'b1;
        S_DONE:
          if (!all_vtc) begin
            st <= S_ERR; err_lock <= 1'b1;
          end
        S_ERR:
          if (restart) begin
            st <= S_HOLD; cnt <= '0; ctrl_rst <= 1'b1;
            err_timeout <= 1'b0; err_lock <= 1'b0;
          end
        default: st <= S_ERR;
      endcase
    end

  assign en_track     = (st == S_EN) || (st == S_WVTC) || (st == S_DONE);
  assign bringup_done = (st == S_DONE);

  AST_TRACK_NEEDS_DLY: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(en_track) |-> $past(&dly_s)); // R4
  AST_NO_TRACK_IN_RESET: assert property (@(posedge clk) disable iff (sys_rst)
    ctrl_rst |-> !en_track); // R2
  AST_TRACK_HELD: assert property (@(posedge clk) disable iff (sys_rst)
    $fell(en_track) |-> (err_timeout || err_lock)); // R5
  AST_DONE_NEEDS_VTC: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(bringup_done) |-> $past(&vtc_s)); // R6
  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (sys_rst)
    (bringup_done && !(&vtc_s)) |=> err_lock); // R9
  AST_RST_ON_RESTART: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(ctrl_rst) |-> $past(restart)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (sys_rst)
    $onehot0({bringup_done, err_timeout, err_lock})); // R11
  AST_ERR_NO_RST: assert property (@(posedge clk) disable iff (sys_rst)
    (err_timeout || err_lock) |-> !ctrl_rst); // R11

endmodule

// File: tb/sim_dlycal_bringup.sv
`timescale 1ns/1ps
module sim_dlycal_bringup;
  localparam int N = 3, H = 5, DT = 40, VT = 30;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic sys_rst = 1'b1, restart = 1'b0;
  logic [N-1:0] dly_rdy_in = '0, vtc_rdy_in = '0;
  logic ctrl_rst, en_track, bringup_done, err_timeout, err_lock;

  dlycal_bringup #(.N_CTRL(N), .HOLD_CYCLES(H), .DLY_TIMEOUT(DT), .VTC_TIMEOUT(VT)) u0 (
    .clk(clk), .sys_rst(sys_rst), .restart(restart),
    .dly_rdy_in(dly_rdy_in), .vtc_rdy_in(vtc_rdy_in),
    .ctrl_rst(ctrl_rst), .en_track(en_track), .bringup_done(bringup_done),
    .err_timeout(err_timeout), .err_lock(err_lock));

  int checks = 0, errors = 0, cyc = 0;
  int dly_lat[N], vtc_lat[N];
  bit dly_stuck = 0, vtc_stuck = 0, vtc_drop = 0, en_seen = 0, en_prev = 0;
  int rel_cnt = 0, trk_cnt = 0, rst_len = 0, last_hold = 0, dly_rise = 0, en_rise = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model
  int m_st, m_cnt;
  bit m_rst, m_et, m_el, dq1, dq2, vq1, vq2, ad, av;
  always @(posedge clk or posedge sys_rst) begin
    if (sys_rst) begin
      m_st = 0; m_cnt = 0; m_rst = 1; m_et = 0; m_el = 0;
      dq1 = 0; dq2 = 0; vq1 = 0; vq2 = 0;
    end else begin
      ad = dq2; av = vq2;
      dq2 = dq1; dq1 = &dly_rdy_in;
      vq2 = vq1; vq1 = &vtc_rdy_in;
      case (m_st)
        0: if (m_cnt == H - 1) begin m_st = 1; m_cnt = 0; m_rst = 0; end else m_cnt++;
        1: if (ad) begin m_st = 2; m_cnt = 0; end
           else if (m_cnt == DT - 1) begin m_st = 5; m_et = 1; end else m_cnt++;
        2: begin m_st = 3; m_cnt = 0; end
        3: if (av) m_st = 4;
           else if (m_cnt == VT - 1) begin m_st = 5; m_et = 1; end else m_cnt++;
        4: if (!av) begin m_st = 5; m_el = 1; end
        default: if (restart) begin m_st = 0; m_cnt = 0; m_rst = 1; m_et = 0; m_el = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    bit prev_all;
    cyc++;
    chk(ctrl_rst === m_rst, "R2", "ctrl_rst", ctrl_rst, m_rst);
    chk(en_track === (m_st >= 2 && m_st <= 4), "R4", "en_track", en_track, (m_st >= 2 && m_st <= 4));
    chk(bringup_done === (m_st == 4), "R6", "bringup_done", bringup_done, (m_st == 4));
    chk(err_timeout === m_et, "R7", "err_timeout", err_timeout, m_et);
    chk(err_lock === m_el, "R9", "err_lock", err_lock, m_el);
    if (en_track) en_seen = 1;
    if (en_track && !en_prev) en_rise = cyc;
    en_prev = en_track;
    if (!sys_rst && ctrl_rst) rst_len++;
    else if (!ctrl_rst && rst_len != 0) begin last_hold = rst_len; rst_len = 0; end
    // controller models
    prev_all = &dly_rdy_in;
    if (ctrl_rst) rel_cnt = 0; else rel_cnt++;
    if (!en_track) trk_cnt = 0; else trk_cnt++;
    for (int i = 0; i < N; i++) begin
      dly_rdy_in[i] = !ctrl_rst && rel_cnt >= dly_lat[i] && !(dly_stuck && i == 0);
      vtc_rdy_in[i] = en_track && trk_cnt >= vtc_lat[i] && !(vtc_stuck && i == N-1) && !(vtc_drop && i == 1);
    end
    if (!prev_all && &dly_rdy_in) dly_rise = cyc;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic new_lat();
    for (int i = 0; i < N; i++) begin
      dly_lat[i] = $urandom_range(1, 20);
      vtc_lat[i] = $urandom_range(1, 15);
    end
  endtask

  task automatic pulse_restart();
    restart = 1; step(1); restart = 0;
  endtask

  task automatic run_to_done(string tag);
    for (int k = 0; k < 200 && !bringup_done; k++) step(1);
    chk(bringup_done, "R6", {tag, " done reached"}, bringup_done, 1);
    chk(en_track, "R5", {tag, " enable high when done"}, en_track, 1);
    chk(last_hold == H, "R2", {tag, " hold length"}, last_hold, H);
    chk(en_rise - dly_rise == 3, "R3", {tag, " sync delay"}, en_rise - dly_rise, 3);
  endtask

  initial begin
    new_lat();
    step(3);
    chk(ctrl_rst && !en_track && !bringup_done && !err_timeout && !err_lock, "R1",
        "reset state", {ctrl_rst, en_track, bringup_done, err_timeout, err_lock}, 5'b10000);
    sys_rst = 0;
    run_to_done("first");
    step(20);
    chk(en_track && bringup_done, "R5", "enable held in done", en_track, 1);
    pulse_restart(); step(5);
    chk(!ctrl_rst && bringup_done, "R10", "restart ignored when done", ctrl_rst, 0);
    vtc_drop = 1; step(6);
    chk(err_lock && !en_track && !bringup_done, "R9", "lock loss flagged", err_lock, 1);
    step(30);
    chk(err_lock && !ctrl_rst, "R11", "lock error held", err_lock, 1);
    vtc_drop = 0; dly_stuck = 1; new_lat(); en_seen = 0;
    pulse_restart();
    chk(ctrl_rst && !err_lock, "R10", "restart accepted from error", ctrl_rst, 1);
    for (int k = 0; k < H + DT + 20 && !err_timeout; k++) step(1);
    chk(err_timeout, "R7", "delay-ready timeout", err_timeout, 1);
    chk(!en_seen, "R4", "enable never raised on partial ready", en_seen, 0);
    step(10);
    chk(err_timeout && !ctrl_rst && !en_track, "R11", "timeout held", err_timeout, 1);
    dly_stuck = 0; vtc_stuck = 1; en_seen = 0;
    pulse_restart();
    for (int k = 0; k < H + DT + VT + 40 && !err_timeout; k++) step(1);
    chk(err_timeout && en_seen && !en_track, "R8", "tracking-ready timeout", err_timeout, 1);
    vtc_stuck = 0;
    for (int r = 0; r < 4; r++) begin
      new_lat();
      pulse_restart();
      run_to_done("rerun");
      vtc_drop = 1; step(6); vtc_drop = 0;
      chk(err_lock, "R9", "rerun lock loss", err_lock, 1);
    end
    pulse_restart();
    run_to_done("final");
    #0.5 sys_rst = 1; #0.5;
    chk(ctrl_rst && !en_track && !bringup_done, "R1", "async reset assert", ctrl_rst, 1);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule